// File: doc/BRIEF.md
# Banked Lane FIFO Stream Serializer

This block accepts a vector of four complex samples per clock, one sample per lane, and stores each lane in a FIFO bank of its own. Every bank sees at most one write per clock, so each can map onto an ordinary single-write-port memory. A read sequencer visits the banks in a fixed rotation and sends one sample per clock out on an AXI4-Stream port. Because lane k carries bins k, k+4, k+8 and so on, the rotation puts the bins back in natural order.

Each stored word holds a 25-bit real part, a 25-bit imaginary part and a frame-end flag in the least significant bit. After the output multiplexer the flag is split off and driven on tlast. The sample is packed into a 64-bit tdata word. A low tready halts the rotation, and samples then collect in the banks. A write to a full bank is dropped and reported on a per-bank error pulse.

Top module: `lane_serializer`

## Requirements
- R1: When `in_valid` is high, lane k of the input vector is written only into bank k. The output then emits lane 0, 1, 2, 3 of the oldest unsent vector in that order, and vectors leave in arrival order.
- R2: Each bank holds 128 entries. While `m_tready` is low, 128 vectors (a 512-bin frame) are accepted with no overflow, and every one of them is later emitted unchanged.
- R3: `m_tdata[24:0]` carries the real part and `m_tdata[49:25]` the imaginary part of the emitted sample. `m_tdata[63:50]` is zero.
- R4: `m_tlast` equals the frame-end flag (`in_eof` bit of that lane) stored with the emitted sample, so it is high only on the beat carrying a flagged sample.
- R5: A round of four reads starts only when all four banks hold an entry. With all banks empty `m_tvalid` is low, and it goes high in the cycle after a vector is written.
- R6: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tlast` hold their values and no sample is lost.
- R7: The lane rotation advances only on an accepted beat (`m_tvalid` and `m_tready` both high), so any tready pattern yields the same output order.
- R8: A write into a full bank is dropped and leaves the stored contents intact. `ovf_err[k]` goes high for exactly the one cycle after a write was dropped in bank k.
- R9: After a synchronous active-low reset every bank is empty, `m_tvalid` is low and `ovf_err` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input vector valid; writes all lanes |
| in_re | input | 100 | Real parts; lane k in bits [25k+24:25k] |
| in_im | input | 100 | Imaginary parts; lane k in bits [25k+24:25k] |
| in_eof | input | 4 | Frame-end flag per lane |
| m_tdata | output | 64 | Packed output sample |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream ready |
| m_tlast | output | 1 | Frame-end flag of the current beat |
| ovf_err | output | 4 | Per-bank dropped-write pulse |

## Verification
Suppose the rotation pointer or a bank's read pointer is in the wrong state. Then the very next accepted beat carries a sample out of order, so the bench tags each sample with its arrival index and compares every beat. A wrong occupancy count shows up in one of two ways. It can raise `m_tvalid` on an empty bank, which is caught when the drain reports a beat count beyond the number written. It can also drop or admit a write at the capacity edge, which shows within a cycle on `ovf_err` and later as a missing or extra sample. Stall faults are checked on each stalled cycle against the value held in the cycle before.

// File: rtl/lane_ser_pkg.sv
// Package: default geometry shared by the lane serializer modules.
// Assumes: one sample per lane per clock, data word = {im, re, eof}.
package lane_ser_pkg;
    localparam int SAMPLE_W   = 25;
    localparam int N_LANES    = 4;
    localparam int BANK_DEPTH = 128;
    localparam int AXIS_W     = 64;
endpackage

// File: rtl/lane_bank.sv
// Module: single-write, single-read FIFO bank with a look-ahead head word.
// Assumes: at most one push and one pop per clock; a push into a full bank
// is dropped (even when a pop occurs that cycle) and pulses ovf next cycle.
module lane_bank #(
    parameter int WORD_W = 51,
    parameter int DEPTH  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] wdata,
    input  logic              pop,
    output logic [WORD_W-1:0] rdata,
    output logic              empty,
    output logic              full,
    output logic              ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count;
    logic              do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // Storage write: only accepted pushes touch the array.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer, occupancy and overflow pulse bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            ovf <= push && full;
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R8: a dropped write raises ovf and leaves the write pointer alone.
    a_r8_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> (ovf && $stable(wr_ptr)));

    // R2: occupancy never exceeds the bank depth.
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R5: the sequencer never pops an empty bank.
    a_r5_no_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/rr_sequencer.sv
// Module: round-robin read scheduler over the lane banks.
// Assumes: banks are written in whole vectors, so a round may begin only
// when every bank is non-empty; the lane pointer moves only on a handshake.
module rr_sequencer #(
    parameter int LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LANES-1:0]     empty,
    input  logic                 tready,
    output logic                 tvalid,
    output logic [((LANES > 1) ? $clog2(LANES) : 1)-1:0] sel,
    output logic [LANES-1:0]     pop
);
    localparam int SW = (LANES > 1) ? $clog2(LANES) : 1;

    logic [SW-1:0] ptr;
    logic          all_avail;
    logic          fire;

    assign sel       = ptr;
    assign all_avail = ~|empty;
    assign fire      = tvalid && tready;

    // Valid gating: round start needs all banks, mid-round the current bank.
    always_comb begin
        if (ptr == '0) tvalid = all_avail;
        else           tvalid = !empty[ptr];
    end

    // Pop decode: one bank per accepted beat.
    always_comb begin
        pop = '0;
        if (fire) pop[ptr] = 1'b1;
    end

    // Lane pointer: advance and wrap on each accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr <= '0;
        else if (fire) ptr <= (ptr == SW'(LANES - 1)) ? '0 : ptr + 1'b1;
    end

    // R7: no handshake, no pointer movement.
    a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(ptr));

    // R1: at most one bank is read per clock.
    a_r1_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop));

    // R5: a round begins only with every bank holding data.
    a_r5_round_start: assert property (@(posedge clk) disable iff (!rst_n)
        (tvalid && ptr == '0) |-> (empty == '0));
endmodule

// File: rtl/stream_pack.sv
// Module: splits the frame-end flag off a bank word and packs the sample.
// Assumes: word layout {im, re, eof}; tdata = {zeros, im, re}.
module stream_pack #(
    parameter int SAMPLE_W = 25,
    parameter int AXIS_W   = 64
) (
    input  logic [2*SAMPLE_W:0] word,
    output logic [AXIS_W-1:0]   tdata,
    output logic                tlast
);
    localparam int PAD_W = AXIS_W - 2 * SAMPLE_W;

    // Packing: sample bits low, zero fill high, flag to tlast.
    always_comb begin
        tdata = {{PAD_W{1'b0}}, word[2*SAMPLE_W:1]};
        tlast = word[0];
    end
endmodule

// File: rtl/lane_serializer.sv
// Module: top of the banked lane FIFO stream serializer.
// Assumes: all lanes of a vector are written together on in_valid; output
// follows AXI4-Stream valid/ready rules; reset is synchronous active-low.
module lane_serializer
    import lane_ser_pkg::*;
#(
    parameter int LANES = N_LANES,
    parameter int DEPTH = BANK_DEPTH,
    parameter int SW_S  = SAMPLE_W,
    parameter int TDW   = AXIS_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [LANES*SW_S-1:0] in_re,
    input  logic [LANES*SW_S-1:0] in_im,
    input  logic [LANES-1:0]      in_eof,
    output logic [TDW-1:0]        m_tdata,
    output logic                  m_tvalid,
    input  logic                  m_tready,
    output logic                  m_tlast,
    output logic [LANES-1:0]      ovf_err
);
    localparam int WORD_W = 2 * SW_S + 1;
    localparam int SELW   = (LANES > 1) ? $clog2(LANES) : 1;

    logic [WORD_W-1:0] head [LANES];
    logic [LANES-1:0]  empty, full, pop;
    logic [SELW-1:0]   sel;
    logic [WORD_W-1:0] out_word;

    // Bank array: lane k feeds bank k only.
    for (genvar k = 0; k < LANES; k++) begin : g_bank
        lane_bank #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (in_valid),
            .wdata ({in_im[k*SW_S +: SW_S], in_re[k*SW_S +: SW_S], in_eof[k]}),
            .pop   (pop[k]),
            .rdata (head[k]),
            .empty (empty[k]),
            .full  (full[k]),
            .ovf   (ovf_err[k])
        );
    end

    rr_sequencer #(.LANES(LANES)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .empty  (empty),
        .tready (m_tready),
        .tvalid (m_tvalid),
        .sel    (sel),
        .pop    (pop)
    );

    // Output multiplexer: head word of the selected bank.
    assign out_word = head[sel];

    stream_pack #(.SAMPLE_W(SW_S), .AXIS_W(TDW)) u_pack (
        .word  (out_word),
        .tdata (m_tdata),
        .tlast (m_tlast)
    );

    // R6: a stalled beat holds its payload and stays valid.
    a_r6_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

    // R3: the pad above the sample is always zero.
    a_r3_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> (m_tdata[TDW-1:2*SW_S] == '0));

    // R8: an error pulse only follows a write attempt on a full bank.
    a_r8_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_err != '0) |-> $past(in_valid && (full != '0)));
endmodule

// File: tb/lane_serializer_tb.sv
module lane_serializer_tb;
    localparam int L = 4;
    localparam int S = 25;
    localparam int D = 128;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [L*S-1:0] in_re = '0;
    logic [L*S-1:0] in_im = '0;
    logic [L-1:0]   in_eof = '0;
    logic [63:0]    m_tdata;
    logic           m_tvalid;
    logic           m_tready = 1'b0;
    logic           m_tlast;
    logic [L-1:0]   ovf_err;

    int n_checks = 0;
    int n_err    = 0;
    int wr_n     = 0;
    int rd_n     = 0;
    int last_seen = 0;
    bit ovf_seen = 1'b0;
    bit bp_mode  = 1'b0;
    bit mon_on   = 1'b0;
    bit done     = 1'b0;
    int cyc      = 0;

    lane_serializer u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re),
        .in_im(in_im), .in_eof(in_eof), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
        .m_tready(m_tready), .m_tlast(m_tlast), .ovf_err(ovf_err)
    );

    always #10 clk = ~clk;

    function automatic logic [S-1:0] re_of(int n);
        return S'(n * 37 + 5);
    endfunction
    function automatic logic [S-1:0] im_of(int n);
        return S'(n * 101) ^ 25'h1555555;
    endfunction
    function automatic logic eof_of(int n);
        return (n % 512) == 511;
    endfunction
    function automatic logic [63:0] exp_data(int n);
        return {14'b0, im_of(n), re_of(n)};
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    endtask

    // Drive one vector carrying samples n..n+3 (or a marker vector).
    task automatic push_vec(bit marker);
        for (int k = 0; k < L; k++) begin
            in_re[k*S +: S] = marker ? 25'h0ABCDE : re_of(wr_n + k);
            in_im[k*S +: S] = marker ? 25'h1FEDCB : im_of(wr_n + k);
            in_eof[k]       = marker ? 1'b1 : eof_of(wr_n + k);
        end
        in_valid = 1'b1;
        @(posedge clk); #1;
        in_valid = 1'b0;
        if (!marker) wr_n += L;
    endtask

    task automatic push_many(int nv);
        for (int v = 0; v < nv; v++) push_vec(1'b0);
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Cycle counter and backpressure pattern.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (bp_mode) m_tready <= #1 (((cyc * 7) % 5) < 2);
    end

    // Beat monitor: order, packing, tlast and stall stability (R1,R3,R4,R6,R7).
    logic [63:0] prev_data;
    logic        prev_last;
    bit          prev_stall = 1'b0;
    always @(negedge clk) begin
        if (mon_on) begin
            if (ovf_err != '0) ovf_seen = 1'b1;
            if (prev_stall) begin
                chk(m_tvalid && m_tdata == prev_data && m_tlast == prev_last,
                    "R6 stall hold", m_tdata, prev_data);
            end
            if (m_tvalid && m_tready) begin
                if (rd_n >= wr_n) begin
                    chk(1'b0, "R5 beat with nothing written", 64'(rd_n), 64'(wr_n));
                end else begin
                    chk(m_tdata == exp_data(rd_n), "R1 R3 R7 order and packing",
                        m_tdata, exp_data(rd_n));
                    chk(m_tlast == eof_of(rd_n), "R4 tlast", 64'(m_tlast), 64'(eof_of(rd_n)));
                    if (m_tlast) last_seen++;
                end
                rd_n++;
            end
            prev_stall = m_tvalid && !m_tready;
            prev_data  = m_tdata;
            prev_last  = m_tlast;
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        wait_cyc(3);
        @(negedge clk);
        chk(m_tvalid == 1'b0, "R9 reset tvalid", 64'(m_tvalid), 64'd0);
        chk(ovf_err == '0, "R9 reset ovf", 64'(ovf_err), 64'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        mon_on = 1'b1;
        wait_cyc(2);
        @(negedge clk);
        chk(m_tvalid == 1'b0, "R5 empty banks no valid", 64'(m_tvalid), 64'd0);
        @(posedge clk); #1;

        // Single vector with ready high.
        m_tready = 1'b1;
        push_vec(1'b0);
        wait_cyc(8);
        chk(rd_n == 4, "R1 single vector beats", 64'(rd_n), 64'd4);
        @(negedge clk);
        chk(m_tvalid == 1'b0, "R5 drained no valid", 64'(m_tvalid), 64'd0);
        @(posedge clk); #1;

        // Continuous frame while draining at full rate.
        push_many(128);
        wait_cyc(600);
        chk(rd_n == wr_n, "R1 continuous frame count", 64'(rd_n), 64'(wr_n));
        chk(ovf_seen == 1'b0, "R8 no spurious overflow", 64'(ovf_seen), 64'd0);

        // Irregular backpressure.
        bp_mode = 1'b1;
        push_many(100);
        wait_cyc(1200);
        bp_mode = 1'b0;
        @(posedge clk); #1;
        m_tready = 1'b0;
        wait_cyc(2);
        chk(rd_n == wr_n, "R7 backpressure drain count", 64'(rd_n), 64'(wr_n));
        chk(ovf_seen == 1'b0, "R6 no loss under backpressure", 64'(ovf_seen), 64'd0);

        // Stalled fill to capacity, then one extra vector.
        m_tready = 1'b0;
        push_vec(1'b0);
        @(negedge clk);
        chk(m_tvalid == 1'b1, "R5 valid after first write", 64'(m_tvalid), 64'd1);
        chk(m_tdata == exp_data(rd_n), "R3 head while stalled", m_tdata, exp_data(rd_n));
        @(posedge clk); #1;
        push_many(D - 1);
        @(negedge clk);
        chk(ovf_err == '0, "R2 full frame no overflow", 64'(ovf_err), 64'd0);
        @(posedge clk); #1;
        push_vec(1'b1);
        @(negedge clk);
        chk(ovf_err == 4'hF, "R8 overflow pulse", 64'(ovf_err), 64'hF);
        @(posedge clk); #1;
        @(negedge clk);
        chk(ovf_err == '0, "R8 pulse one cycle", 64'(ovf_err), 64'd0);
        @(posedge clk); #1;
        last_seen = 0;
        m_tready = 1'b1;
        wait_cyc(600);
        chk(rd_n == wr_n, "R2 R8 frame intact after drop", 64'(rd_n), 64'(wr_n));
        chk(last_seen == 1, "R4 one tlast per frame", 64'(last_seen), 64'd1);
        @(negedge clk);
        chk(m_tvalid == 1'b0, "R8 dropped vector never emitted", 64'(m_tvalid), 64'd0);
        finish_run();
    end
endmodule